// File: doc/BRIEF.md
# Programmable Lookup Table with Memory Mode

This block is a bank of small lookup tables that share one select bus. Each table holds one storage bit for every row of a truth table over `ADDR_W` inputs. The select inputs address one bit per table, and that bit drives the table's output line. Whatever pattern is held in the cells therefore defines an arbitrary Boolean function of the select inputs. The default build has two tables of four inputs each.

The cells are filled by a serial configuration stream with one bit lane per table. Each clock that the load strobe is high shifts one bit into every table. The highest address is sent first.

When memory mode is enabled, the same cells become a user-writable RAM. Writes are synchronous: one word is written per rising edge at the select address. Reads are combinational, and a read is exactly the function-evaluation path. The default two tables thus form a 16-word by 2-bit memory.

Top module: `prog_lut`

## Requirements
- R1: While `rstN` is low, every cell of every table is cleared, so `dataOut` reads 0 at any `sel` after reset.
- R2: At all times, `dataOut[j]` equals the cell of table j at address `sel`, as combinational logic with no clock delay. This holds in logic mode and memory mode alike.
- R3: On each rising edge with `cfgLoad` high, every table shifts up by one address. Bit `cfgBit[j]` enters address 0 of table j, and the bit at the top address is dropped. After 16 loads, the first bit sent sits at address 15, so a pattern is sent most significant address first.
- R4: On an edge with `cfgLoad` low and no write, all cells hold their value.
- R5: On an edge with `ramMode`=1, `wrEn`=1 and `cfgLoad`=0, `wrData[j]` is stored at address `sel` of table j. No other cell changes.
- R6: With `ramMode`=0, `wrEn` has no effect and the programmed function is unchanged.
- R7: When `cfgLoad` and a memory write fall on the same edge, the configuration shift takes place and the write is dropped.
- R8: When a write targets the address being read, `dataOut` shows the old value until the write edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shifts and memory writes |
| rstN | input | 1 | Asynchronous active-low reset that clears all cells |
| cfgLoad | input | 1 | Serial configuration shift enable |
| cfgBit | input | DATA_W | Serial configuration bit, one per table |
| ramMode | input | 1 | 1 = cells are user-writable memory, 0 = fixed logic function |
| wrEn | input | 1 | Memory write enable |
| wrData | input | DATA_W | Memory write word, one bit per table |
| sel | input | ADDR_W | Logic inputs, which also serve as the memory address |
| dataOut | output | DATA_W | Selected cell of each table |

## Verification
The case that needs the most care is a configuration shift and a memory write arriving on the same edge. Both update the same cells, so only one of them may win. The bench raises `cfgLoad`, `ramMode` and `wrEn` together at address 0, with the write word chosen to differ from the incoming configuration bits. After the edge, the word at address 0 must equal the shifted-in configuration bits, and the higher addresses must show the rest of the old contents moved up by one.

// File: rtl/prog_lut_pkg.sv
package prog_lut_pkg;
  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic cfgShift;
    logic ramWrite;
  } lutStrobes_t;
endpackage

// File: rtl/prog_lut_ctrl.sv
module prog_lut_ctrl
  import prog_lut_pkg::*;
(
  input  logic        cfgLoad,
  input  logic        ramMode,
  input  logic        wrEn,
  output lutStrobes_t strobes
);
  // configuration outranks user writes; writes need memory mode
  always_comb begin
    strobes.cfgShift = cfgLoad;
    strobes.ramWrite = ramMode & wrEn & ~cfgLoad;
  end
endmodule

// File: rtl/prog_lut_store.sv
module prog_lut_store
  import prog_lut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lutStrobes_t       strobes,
  input  logic [DATA_W-1:0] cfgBit,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] sel,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar j = 0; j < DATA_W; j++) begin : g_table
    logic [DEPTH-1:0] cells;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cells <= '0;
      end else if (strobes.cfgShift) begin
        cells <= {cells[DEPTH-2:0], cfgBit[j]};
      end else if (strobes.ramWrite) begin
        cells[sel] <= wrData[j];
      end
    end

    // read path: same for logic evaluation and memory read
    assign dataOut[j] = cells[sel];
  end
endmodule

// File: rtl/prog_lut.sv
module prog_lut
  import prog_lut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [DATA_W-1:0] cfgBit,
  input  logic              ramMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] sel,
  output logic [DATA_W-1:0] dataOut
);
  lutStrobes_t strobes;

  prog_lut_ctrl u_ctrl (
    .cfgLoad (cfgLoad),
    .ramMode (ramMode),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  prog_lut_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cfgBit  (cfgBit),
    .wrData  (wrData),
    .sel     (sel),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/prog_lut_chk.sv
module prog_lut_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic [DATA_W-1:0] cfgBit,
  input logic              ramMode,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] sel,
  input logic [DATA_W-1:0] dataOut
);
  // R5 R8: a memory write is visible at the same address right after the edge
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (ramMode && wrEn && !cfgLoad) ##1 $stable(sel) |-> dataOut == $past(wrData));

  // R4 R6: with no shift and no legal write, a steady address gives a steady output
  a_r6_logic_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLoad && !(ramMode && wrEn)) ##1 $stable(sel) |-> $stable(dataOut));

  // R3 R7: a shift puts the serial bit at address 0, even against a write
  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad ##1 (sel == '0) |-> dataOut == $past(cfgBit));

  // R7: a colliding write must not land when its data differs from the shifted bit
  a_r7_cfg_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && ramMode && wrEn && sel == '0 && wrData != cfgBit) ##1 (sel == '0)
      |-> dataOut != $past(wrData));

  // R1: no unknown output once out of reset
  a_r1_known: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(dataOut));
endmodule

bind prog_lut prog_lut_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgLoad (cfgLoad),
  .cfgBit  (cfgBit),
  .ramMode (ramMode),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .sel     (sel),
  .dataOut (dataOut)
);

// File: tb/prog_lut_test.sv
module prog_lut_test;
  localparam int AW = 4;
  localparam int DW = 2;
  localparam logic [15:0] PAT0 = 16'hA5C3;
  localparam logic [15:0] PAT1 = 16'h6E19;

  // vector: {ramMode, wrEn, sel[3:0], wrData[1:0]}
  localparam int NVEC = 8;
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 4'd3,  2'b10},
    {1'b0, 1'b1, 4'd5,  2'b11},
    {1'b1, 1'b0, 4'd7,  2'b00},
    {1'b1, 1'b1, 4'd15, 2'b01},
    {1'b1, 1'b1, 4'd0,  2'b11},
    {1'b0, 1'b1, 4'd0,  2'b00},
    {1'b1, 1'b1, 4'd3,  2'b01},
    {1'b0, 1'b0, 4'd9,  2'b11}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [DW-1:0] cfgBit = '0;
  logic ramMode = 1'b0;
  logic wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] sel = '0;
  logic [DW-1:0] dataOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] m0, m1;

  always #2 clk = ~clk;

  prog_lut #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgBit(cfgBit),
    .ramMode(ramMode), .wrEn(wrEn), .wrData(wrData), .sel(sel), .dataOut(dataOut)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: cleared cells after reset
    sel = 4'd0; #1; check("R1 sel0", dataOut, 2'b00);
    sel = 4'd9; #1; check("R1 sel9", dataOut, 2'b00);
    rstN = 1'b1;
    tick();
    check("R1 after release", dataOut, 2'b00);

    // R3: serial load, top address first
    for (int i = 15; i >= 0; i--) begin
      cfgLoad = 1'b1;
      cfgBit = {PAT1[i], PAT0[i]};
      tick();
    end
    cfgLoad = 1'b0;
    for (int a = 0; a < 16; a++) begin
      sel = a[AW-1:0]; #1;
      check("R3/R2 loaded function", dataOut, {PAT1[a], PAT0[a]});
    end

    // R4: hold with no shift and no write
    sel = 4'd6; tick(); tick();
    check("R4 hold", dataOut, {PAT1[6], PAT0[6]});

    // R5 R6 R8: vector walk
    m0 = PAT0; m1 = PAT1;
    for (int v = 0; v < NVEC; v++) begin
      ramMode = VEC[v][7];
      wrEn = VEC[v][6];
      sel = VEC[v][5:2];
      wrData = VEC[v][1:0];
      #1;
      check("R8 before edge", dataOut, {m1[sel], m0[sel]});
      if (VEC[v][7] && VEC[v][6]) begin
        m0[sel] = VEC[v][0];
        m1[sel] = VEC[v][1];
      end
      tick();
      check(VEC[v][7] ? "R5 after edge" : "R6 after edge", dataOut, {m1[sel], m0[sel]});
    end
    wrEn = 1'b0;
    for (int a = 0; a < 16; a++) begin
      sel = a[AW-1:0]; #1;
      check("R5/R6 whole table", dataOut, {m1[a], m0[a]});
    end

    // R7: shift and write on the same edge at address 0
    sel = 4'd0; ramMode = 1'b1; wrEn = 1'b1; wrData = 2'b10;
    cfgLoad = 1'b1; cfgBit = 2'b01;
    tick();
    cfgLoad = 1'b0; wrEn = 1'b0;
    #1;
    check("R7 shift wins at addr0", dataOut, 2'b01);
    for (int a = 1; a < 16; a++) begin
      sel = a[AW-1:0]; #1;
      check("R7 contents moved up", dataOut, {m1[a-1], m0[a-1]});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule